// File: doc/BRIEF.md
# Processor Address Space Decoder

This block sits between the processor's 16-bit address bus and all the units that answer it. It decodes the top nibble of each address into one target region. It mirrors the small regions across their windows. It emits one read or write strobe per target and returns read data. The read data is taken from the selected source, or zero when nothing readable is addressed. The targets are the work RAM, the video register file, the audio registers, two controller ports, the sprite-DMA start and the cartridge port.

Two video registers have side effects on the interrupt logic, and the block produces those side effects as one-cycle pulses:
- A status read that lands on dot 2 or 3 of the video timing suppresses the pending NMI.
- A control write that disables NMI while the late-NMI flag is set also suppresses it.
- A control write that enables NMI during vertical blank requests a delayed NMI.

Strobes and read data are combinational. They assume the processor holds `busRd` or `busWr` high for exactly one cycle per access. The two interrupt pulses are registered and appear in the cycle after the access.

Top module: `cpu_addr_decode`

## Requirements
- R1: Addresses 0x0000–0x1FFF select work RAM. A read raises `ramRd`, a write raises `ramWr`, and `ramAddr` carries address bits [10:0], so the 2 KB array appears four times. A read returns `ramRdata`.
- R2: Addresses 0x2000–0x3FFF select the video register file, with `vidReg` = address bits [2:0], so the eight registers repeat every 8 bytes. A write raises `vidWr` for every register except 2, whose writes produce no strobe.
- R3: In the video window, reads of registers 2, 4 and 7 raise `vidRd` and return `vidRdata`. Reads of registers 0, 1, 3, 5 and 6 raise no strobe and return 0.
- R4: In page 0x4xxx, a read of 0x4015 raises `apuRd` and returns `apuStatus`. A read of 0x4016 or 0x4017 returns controller port 0 or 1 data, raising `ctlRd[0]` or `ctlRd[1]`, but only when that port's `ctlPresent` bit is 1. Every other read in the page, or of an absent port, returns 0 with no strobe.
- R5: In page 0x4xxx, these writes raise `apuWr` with `apuAddr` = address bits [4:0]:
  - 0x4000–0x4013, except 0x4009 and 0x400D;
  - 0x4015;
  - 0x4017.

  A write to 0x4016 raises `ctlWr` for both ports. A write to 0x4014 raises `dmaStart`. Any other write in the page raises nothing.
- R6: Page 0x5xxx reads 0 and raises no strobe on reads or writes.
- R7: Addresses 0x6000–0xFFFF raise `cartRd` or `cartWr`, and a read returns `cartRdata`.
- R8: A status read (video register 2) while `vidDot` is 2 or 3 makes `nmiSuppress` high for exactly the one cycle after the access.
- R9: A write to video register 0 with data bit 7 (NMI enable) at 0, while `lateNmi` is 1, makes `nmiSuppress` high for the one cycle after the access.
- R10: A write to video register 0 with data bit 7 at 1, while `vidNmiEn` is 0 and `vidInVblank` is 1, makes `nmiDelayed` high for the one cycle after the access. It stays low if either condition fails.
- R11: During and right after reset, `nmiSuppress` and `nmiDelayed` are 0. With `busRd` and `busWr` both low, no strobe is raised and `busRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Processor address |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Processor write data |
| busRdata | output | 8 | Read data returned to the processor |
| wrData | output | 8 | Write data forwarded to all targets |
| ramAddr | output | 11 | Work RAM index |
| ramRd | output | 1 | Work RAM read |
| ramWr | output | 1 | Work RAM write |
| ramRdata | input | 8 | Work RAM data |
| vidReg | output | 3 | Video register index |
| vidRd | output | 1 | Video register read |
| vidWr | output | 1 | Video register write |
| vidRdata | input | 8 | Video register data |
| vidDot | input | 9 | Video dot counter |
| vidNmiEn | input | 1 | Current NMI-enable flag of the video unit |
| vidInVblank | input | 1 | Video unit is in vertical blank |
| lateNmi | input | 1 | NMI was raised late in the previous access cycle |
| apuAddr | output | 5 | Audio register offset |
| apuRd | output | 1 | Audio status read |
| apuWr | output | 1 | Audio register write |
| apuStatus | input | 8 | Audio status data |
| ctlPresent | input | 2 | Controller port populated, one bit per port |
| ctlRd | output | 2 | Controller port read, one bit per port |
| ctlWr | output | 1 | Controller strobe write to both ports |
| ctl0Rdata | input | 8 | Controller port 0 data |
| ctl1Rdata | input | 8 | Controller port 1 data |
| dmaStart | output | 1 | Sprite DMA start |
| cartAddr | output | 16 | Cartridge address |
| cartRd | output | 1 | Cartridge read |
| cartWr | output | 1 | Cartridge write |
| cartRdata | input | 8 | Cartridge data |
| nmiSuppress | output | 1 | One-cycle NMI suppression pulse |
| nmiDelayed | output | 1 | One-cycle delayed-NMI request pulse |

## Verification
Each source drives a distinct constant. A read therefore shows which source reached `busRdata`, and a wrongly routed window shows up as the wrong constant rather than only as a wrong strobe.

The address sweep has three parts:
- every byte of the 0x4000–0x401F register block;
- every register slot at several mirror copies of the video window;
- a prime stride through the remaining pages.

These catch range-edge slips, such as the 0x4009/0x400D holes, 0x4014 and 0x4018, and also mirroring mistakes. Each access is run as a read and as a write, so a read hit is told apart from a write hit.

The controller pass is run with port 1 present and then absent. The interrupt pulses are swept over:
- dot values 0 to 5;
- both values of bit 7 in the written data;
- every combination of the enable, vblank and late flags.

This separates each of the three pulse conditions from its near misses.

// File: rtl/cad_pkg.sv
package cad_pkg;
  typedef struct packed {
    logic ramRd;
    logic ramWr;
    logic vidRd;
    logic vidWr;
    logic apuRd;
    logic apuWr;
    logic ctlRd0;
    logic ctlRd1;
    logic ctlWr;
    logic dmaStart;
    logic cartRd;
    logic cartWr;
  } strobe_t;
endpackage

// File: rtl/cad_ctrl.sv
module cad_ctrl
  import cad_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int REG_AW     = 3,
  parameter int APU_AW     = 5,
  parameter int DOT_W      = 9,
  parameter int NMI_EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DOT_W-1:0]  vidDot,
  input  logic              vidNmiEn,
  input  logic              vidInVblank,
  input  logic              lateNmi,
  input  logic [1:0]        ctlPresent,
  output strobe_t           strobes,
  output logic              nmiSuppress,
  output logic              nmiDelayed
);
  localparam int PAGE_LSB = ADDR_W - 4;
  localparam int IO_HI_W  = PAGE_LSB - APU_AW;

  logic [3:0]        page;
  logic [REG_AW-1:0] regIdx;
  logic [APU_AW-1:0] ioOff;
  logic              inRam, inVid, inIo, inCart, ioBlock;
  logic              vidReadable, apuWrHit;
  logic              statusRead, ctrlWrite;
  logic              supNext, delNext;

  assign page   = busAddr[ADDR_W-1:PAGE_LSB];
  assign regIdx = busAddr[REG_AW-1:0];
  assign ioOff  = busAddr[APU_AW-1:0];

  assign inRam   = (page == 4'h0) || (page == 4'h1);
  assign inVid   = (page == 4'h2) || (page == 4'h3);
  assign inIo    = (page == 4'h4);
  assign inCart  = (page >= 4'h6);
  assign ioBlock = inIo && (busAddr[PAGE_LSB-1:APU_AW] == IO_HI_W'(0));

  always_comb begin
    vidReadable = 1'b0;
    case (regIdx)
      REG_AW'(2), REG_AW'(4), REG_AW'(7): vidReadable = 1'b1;
      default: vidReadable = 1'b0;
    endcase
  end

  always_comb begin
    apuWrHit = 1'b0;
    if (ioBlock) begin
      if (ioOff <= APU_AW'(5'h13))
        apuWrHit = (ioOff != APU_AW'(5'h09)) && (ioOff != APU_AW'(5'h0D));
      else if ((ioOff == APU_AW'(5'h15)) || (ioOff == APU_AW'(5'h17)))
        apuWrHit = 1'b1;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.ramRd    = busRd && inRam;
    strobes.ramWr    = busWr && inRam;
    strobes.vidRd    = busRd && inVid && vidReadable;
    strobes.vidWr    = busWr && inVid && (regIdx != REG_AW'(2));
    strobes.apuRd    = busRd && ioBlock && (ioOff == APU_AW'(5'h15));
    strobes.apuWr    = busWr && apuWrHit;
    strobes.ctlRd0   = busRd && ioBlock && (ioOff == APU_AW'(5'h16)) && ctlPresent[0];
    strobes.ctlRd1   = busRd && ioBlock && (ioOff == APU_AW'(5'h17)) && ctlPresent[1];
    strobes.ctlWr    = busWr && ioBlock && (ioOff == APU_AW'(5'h16));
    strobes.dmaStart = busWr && ioBlock && (ioOff == APU_AW'(5'h14));
    strobes.cartRd   = busRd && inCart;
    strobes.cartWr   = busWr && inCart;
  end

  assign statusRead = busRd && inVid && (regIdx == REG_AW'(2));
  assign ctrlWrite  = busWr && inVid && (regIdx == REG_AW'(0));

  assign supNext = (statusRead && ((vidDot == DOT_W'(2)) || (vidDot == DOT_W'(3))))
                || (ctrlWrite && !busWdata[NMI_EN_BIT] && lateNmi);
  assign delNext = ctrlWrite && busWdata[NMI_EN_BIT] && !vidNmiEn && vidInVblank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiSuppress <= 1'b0;
      nmiDelayed  <= 1'b0;
    end else begin
      nmiSuppress <= supNext;
      nmiDelayed  <= delNext;
    end
  end
endmodule

// File: rtl/cad_datapath.sv
module cad_datapath
  import cad_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11,
  parameter int REG_AW = 3,
  parameter int APU_AW = 5
) (
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic [DATA_W-1:0] vidRdata,
  input  logic [DATA_W-1:0] apuStatus,
  input  logic [DATA_W-1:0] ctl0Rdata,
  input  logic [DATA_W-1:0] ctl1Rdata,
  input  logic [DATA_W-1:0] cartRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] wrData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  output logic [REG_AW-1:0] vidReg,
  output logic              vidRd,
  output logic              vidWr,
  output logic [APU_AW-1:0] apuAddr,
  output logic              apuRd,
  output logic              apuWr,
  output logic [1:0]        ctlRd,
  output logic              ctlWr,
  output logic              dmaStart,
  output logic [ADDR_W-1:0] cartAddr,
  output logic              cartRd,
  output logic              cartWr
);
  localparam int N_SRC = 6;

  logic [N_SRC-1:0]             srcSel;
  logic [N_SRC-1:0][DATA_W-1:0] srcData;

  assign srcSel  = {strobes.ramRd, strobes.vidRd, strobes.apuRd,
                    strobes.ctlRd0, strobes.ctlRd1, strobes.cartRd};
  assign srcData = {ramRdata, vidRdata, apuStatus, ctl0Rdata, ctl1Rdata, cartRdata};

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < N_SRC; i++) begin
      busRdata = busRdata | (srcData[i] & {DATA_W{srcSel[i]}});
    end
  end

  assign wrData   = busWdata;
  assign ramAddr  = busAddr[RAM_AW-1:0];
  assign vidReg   = busAddr[REG_AW-1:0];
  assign apuAddr  = busAddr[APU_AW-1:0];
  assign cartAddr = busAddr;

  assign ramRd    = strobes.ramRd;
  assign ramWr    = strobes.ramWr;
  assign vidRd    = strobes.vidRd;
  assign vidWr    = strobes.vidWr;
  assign apuRd    = strobes.apuRd;
  assign apuWr    = strobes.apuWr;
  assign ctlRd    = {strobes.ctlRd1, strobes.ctlRd0};
  assign ctlWr    = strobes.ctlWr;
  assign dmaStart = strobes.dmaStart;
  assign cartRd   = strobes.cartRd;
  assign cartWr   = strobes.cartWr;
endmodule

// File: rtl/cpu_addr_decode.sv
module cpu_addr_decode
  import cad_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAM_AW     = 11,
  parameter int REG_AW     = 3,
  parameter int APU_AW     = 5,
  parameter int DOT_W      = 9,
  parameter int NMI_EN_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] wrData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramRd,
  output logic              ramWr,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [REG_AW-1:0] vidReg,
  output logic              vidRd,
  output logic              vidWr,
  input  logic [DATA_W-1:0] vidRdata,
  input  logic [DOT_W-1:0]  vidDot,
  input  logic              vidNmiEn,
  input  logic              vidInVblank,
  input  logic              lateNmi,
  output logic [APU_AW-1:0] apuAddr,
  output logic              apuRd,
  output logic              apuWr,
  input  logic [DATA_W-1:0] apuStatus,
  input  logic [1:0]        ctlPresent,
  output logic [1:0]        ctlRd,
  output logic              ctlWr,
  input  logic [DATA_W-1:0] ctl0Rdata,
  input  logic [DATA_W-1:0] ctl1Rdata,
  output logic              dmaStart,
  output logic [ADDR_W-1:0] cartAddr,
  output logic              cartRd,
  output logic              cartWr,
  input  logic [DATA_W-1:0] cartRdata,
  output logic              nmiSuppress,
  output logic              nmiDelayed
);
  strobe_t strobes;

  cad_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .APU_AW(APU_AW),
    .DOT_W(DOT_W), .NMI_EN_BIT(NMI_EN_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .vidDot(vidDot), .vidNmiEn(vidNmiEn),
    .vidInVblank(vidInVblank), .lateNmi(lateNmi), .ctlPresent(ctlPresent),
    .strobes(strobes), .nmiSuppress(nmiSuppress), .nmiDelayed(nmiDelayed)
  );

  cad_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW), .REG_AW(REG_AW), .APU_AW(APU_AW)
  ) u_dp (
    .strobes(strobes), .busAddr(busAddr), .busWdata(busWdata),
    .ramRdata(ramRdata), .vidRdata(vidRdata), .apuStatus(apuStatus),
    .ctl0Rdata(ctl0Rdata), .ctl1Rdata(ctl1Rdata), .cartRdata(cartRdata),
    .busRdata(busRdata), .wrData(wrData), .ramAddr(ramAddr), .ramRd(ramRd),
    .ramWr(ramWr), .vidReg(vidReg), .vidRd(vidRd), .vidWr(vidWr),
    .apuAddr(apuAddr), .apuRd(apuRd), .apuWr(apuWr), .ctlRd(ctlRd),
    .ctlWr(ctlWr), .dmaStart(dmaStart), .cartAddr(cartAddr),
    .cartRd(cartRd), .cartWr(cartWr)
  );
endmodule

// File: rtl/cad_checker.sv
module cad_checker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] busAddr,
  input logic        busRd,
  input logic        busWr,
  input logic [7:0]  busWdata,
  input logic [7:0]  busRdata,
  input logic        ramRd,
  input logic        ramWr,
  input logic        vidRd,
  input logic        vidWr,
  input logic [2:0]  vidReg,
  input logic        apuRd,
  input logic [1:0]  ctlRd,
  input logic        cartRd,
  input logic [8:0]  vidDot,
  input logic        vidNmiEn,
  input logic        vidInVblank,
  input logic        lateNmi,
  input logic        nmiSuppress,
  input logic        nmiDelayed
);
  p_ram_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ramRd || ramWr) |-> (busAddr[15:13] == 3'b000));

  p_reg2_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    vidWr |-> (vidReg != 3'd2));

  p_one_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramRd, vidRd, apuRd, ctlRd, cartRd}));

  p_page5_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[15:12] == 4'h5) |-> (busRdata == 8'h00));

  p_suppress_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    nmiSuppress |-> $past((busRd && busAddr[15:13] == 3'b001 && busAddr[2:0] == 3'd2
                          && (vidDot == 9'd2 || vidDot == 9'd3))
                       || (busWr && busAddr[15:13] == 3'b001 && busAddr[2:0] == 3'd0
                          && !busWdata[7] && lateNmi)));

  p_delayed_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    nmiDelayed |-> $past(busWr && busAddr[15:13] == 3'b001 && busAddr[2:0] == 3'd0
                         && busWdata[7] && !vidNmiEn && vidInVblank));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busRd && !busWr) |-> (busRdata == 8'h00 && !ramWr && !vidWr));
endmodule

bind cpu_addr_decode cad_checker u_cad_checker (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
  .busWdata(busWdata), .busRdata(busRdata), .ramRd(ramRd), .ramWr(ramWr),
  .vidRd(vidRd), .vidWr(vidWr), .vidReg(vidReg), .apuRd(apuRd), .ctlRd(ctlRd),
  .cartRd(cartRd), .vidDot(vidDot), .vidNmiEn(vidNmiEn), .vidInVblank(vidInVblank),
  .lateNmi(lateNmi), .nmiSuppress(nmiSuppress), .nmiDelayed(nmiDelayed)
);

// File: tb/cpu_addr_decode_bench.sv
module cpu_addr_decode_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata, wrData;
  logic [10:0] ramAddr;
  logic        ramRd, ramWr, vidRd, vidWr, apuRd, apuWr, ctlWr, dmaStart, cartRd, cartWr;
  logic [2:0]  vidReg;
  logic [4:0]  apuAddr;
  logic [1:0]  ctlRd;
  logic [15:0] cartAddr;
  logic [8:0]  vidDot = '0;
  logic        vidNmiEn = 1'b0, vidInVblank = 1'b0, lateNmi = 1'b0;
  logic [1:0]  ctlPresent = 2'b11;
  logic        nmiSuppress, nmiDelayed;

  localparam logic [7:0] D_RAM = 8'h11, D_VID = 8'h22, D_APU = 8'h33,
                         D_C0 = 8'h44, D_C1 = 8'h55, D_CART = 8'h66;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cpu_addr_decode u_cpu_addr_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .wrData(wrData),
    .ramAddr(ramAddr), .ramRd(ramRd), .ramWr(ramWr), .ramRdata(D_RAM),
    .vidReg(vidReg), .vidRd(vidRd), .vidWr(vidWr), .vidRdata(D_VID),
    .vidDot(vidDot), .vidNmiEn(vidNmiEn), .vidInVblank(vidInVblank), .lateNmi(lateNmi),
    .apuAddr(apuAddr), .apuRd(apuRd), .apuWr(apuWr), .apuStatus(D_APU),
    .ctlPresent(ctlPresent), .ctlRd(ctlRd), .ctlWr(ctlWr),
    .ctl0Rdata(D_C0), .ctl1Rdata(D_C1), .dmaStart(dmaStart),
    .cartAddr(cartAddr), .cartRd(cartRd), .cartWr(cartWr), .cartRdata(D_CART),
    .nmiSuppress(nmiSuppress), .nmiDelayed(nmiDelayed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, busAddr, act, exp);
    end
  endtask

  // expected read vector {ram,vid,apu,ctl0,ctl1,cart} and data
  function automatic logic [5:0] expRdVec(input logic [15:0] a);
    logic [3:0] pg = a[15:12];
    if (pg <= 4'h1) return 6'b100000;
    if (pg <= 4'h3) return (a[2:0] == 3'd2 || a[2:0] == 3'd4 || a[2:0] == 3'd7) ? 6'b010000 : 6'b0;
    if (pg == 4'h4) begin
      if (a == 16'h4015) return 6'b001000;
      if (a == 16'h4016) return ctlPresent[0] ? 6'b000100 : 6'b0;
      if (a == 16'h4017) return ctlPresent[1] ? 6'b000010 : 6'b0;
      return 6'b0;
    end
    if (pg == 4'h5) return 6'b0;
    return 6'b000001;
  endfunction

  function automatic logic [7:0] expData(input logic [5:0] v);
    case (v)
      6'b100000: return D_RAM;
      6'b010000: return D_VID;
      6'b001000: return D_APU;
      6'b000100: return D_C0;
      6'b000010: return D_C1;
      6'b000001: return D_CART;
      default:   return 8'h00;
    endcase
  endfunction

  // expected write vector {ram,vid,apu,ctl,dma,cart}
  function automatic logic [5:0] expWrVec(input logic [15:0] a);
    logic [3:0] pg = a[15:12];
    int o = int'(a) - 32'h4000;
    if (pg <= 4'h1) return 6'b100000;
    if (pg <= 4'h3) return (a[2:0] == 3'd2) ? 6'b0 : 6'b010000;
    if (pg == 4'h4) begin
      if ((o >= 0 && o <= 19 && o != 9 && o != 13) || o == 21 || o == 23) return 6'b001000;
      if (o == 22) return 6'b000100;
      if (o == 20) return 6'b000010;
      return 6'b0;
    end
    if (pg == 4'h5) return 6'b0;
    return 6'b000001;
  endfunction

  // one access: comb check after inputs settle, pulse check one cycle later
  task automatic access(input logic [15:0] a, input logic rd, input logic [7:0] d,
                        input logic expSup, input logic expDel, input string req);
    logic [5:0] ev;
    @(negedge clk);
    busAddr = a; busRd = rd; busWr = !rd; busWdata = d;
    #1;
    if (rd) begin
      ev = expRdVec(a);
      check({req, " rd strobes"}, 32'({ramRd, vidRd, apuRd, ctlRd[0], ctlRd[1], cartRd}), 32'(ev));
      check({req, " rd data"}, 32'(busRdata), 32'(expData(ev)));
    end else begin
      ev = expWrVec(a);
      check({req, " wr strobes"}, 32'({ramWr, vidWr, apuWr, ctlWr, dmaStart, cartWr}), 32'(ev));
      if (ev[5]) check("R1 ramAddr", 32'(ramAddr), 32'(a[10:0]));
      if (ev[4]) check("R2 vidReg", 32'(vidReg), 32'(a[2:0]));
      if (ev[3]) check("R5 apuAddr", 32'(apuAddr), 32'(a[4:0]));
      if (ev[0]) check("R7 cartAddr", 32'(cartAddr), 32'(a));
    end
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    #1;
    check("R8 R9 nmiSuppress", 32'(nmiSuppress), 32'(expSup));
    check("R10 nmiDelayed", 32'(nmiDelayed), 32'(expDel));
  endtask

  task automatic sweepBoth(input logic [15:0] a, input string req);
    access(a, 1'b1, 8'h00, 1'b0, 1'b0, req);
    access(a, 1'b0, 8'hA5, 1'b0, 1'b0, req);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 reset sup", 32'(nmiSuppress), 0);
    check("R11 reset del", 32'(nmiDelayed), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 idle data", 32'(busRdata), 0);
    check("R11 idle strobes", 32'({ramRd, ramWr, vidRd, vidWr, apuRd, apuWr, ctlRd, ctlWr, dmaStart, cartRd, cartWr}), 0);
    check("R11 after reset sup", 32'(nmiSuppress), 0);

    vidDot = 9'd100;
    // R4 R5: full register block and just past it
    for (int o = 0; o < 40; o++) sweepBoth(16'h4000 + 16'(o), "R4 R5");
    // R2 R3: every slot at several mirrors
    for (int m = 0; m < 1024; m += 97)
      for (int r = 0; r < 8; r++) sweepBoth(16'h2000 + 16'(m * 8 + r), "R2 R3");
    sweepBoth(16'h3FFA, "R2 R3 top");
    // R1 R6 R7: prime stride across all pages
    for (int a = 0; a < 65536; a += 157) sweepBoth(16'(a), "R1 R6 R7");
    sweepBoth(16'h1FFF, "R1 edge");
    sweepBoth(16'h5000, "R6 edge");
    sweepBoth(16'h5FFF, "R6 edge");
    sweepBoth(16'h6000, "R7 edge");
    sweepBoth(16'hFFFF, "R7 edge");
    sweepBoth(16'h0801, "R1 mirror");

    // R4 absent controller port
    ctlPresent = 2'b01;
    access(16'h4017, 1'b1, 8'h00, 1'b0, 1'b0, "R4 absent port");
    access(16'h4016, 1'b1, 8'h00, 1'b0, 1'b0, "R4 present port");
    ctlPresent = 2'b10;
    access(16'h4016, 1'b1, 8'h00, 1'b0, 1'b0, "R4 absent port");
    ctlPresent = 2'b11;

    // R8 status read against dot values
    for (int dt = 0; dt < 6; dt++) begin
      vidDot = 9'(dt);
      access(16'h2002, 1'b1, 8'h00, (dt == 2 || dt == 3), 1'b0, "R8 status read");
      access(16'h3FF2, 1'b1, 8'h00, (dt == 2 || dt == 3), 1'b0, "R8 status mirror");
      access(16'h2004, 1'b1, 8'h00, 1'b0, 1'b0, "R8 other reg");
    end
    vidDot = 9'd2;
    access(16'h2002, 1'b0, 8'h00, 1'b0, 1'b0, "R8 write not read");
    vidDot = 9'd100;

    // R9 R10 control write over all flag combinations
    for (int f = 0; f < 16; f++) begin
      logic b7, en, vb, lt;
      {b7, en, vb, lt} = 4'(f);
      vidNmiEn = en; vidInVblank = vb; lateNmi = lt;
      access(16'h2000, 1'b0, {b7, 7'h15}, (!b7 && lt), (b7 && !en && vb), "R9 R10 ctrl write");
      access(16'h2001, 1'b0, {b7, 7'h15}, 1'b0, 1'b0, "R9 R10 other reg");
    end
    // R10 back-to-back pulses end after one cycle
    vidNmiEn = 1'b0; vidInVblank = 1'b1; lateNmi = 1'b0;
    access(16'h2008, 1'b0, 8'h80, 1'b0, 1'b1, "R10 mirror");
    @(negedge clk); #1;
    check("R10 pulse ends", 32'(nmiDelayed), 0);
    check("R8 pulse ends", 32'(nmiSuppress), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule